// File: doc/BRIEF.md
# Cell Stream Receive Adapter

This block sits between a link receiver and a downstream consumer that expects to read cells one byte at a time, like an asynchronous FIFO. Aligned 53-byte cells arrive on the link side with a start flag on the first byte. Four header bytes come first, then a header check byte, then 48 payload bytes. The adapter recomputes the header check and strips that byte. It stores each accepted cell in an internal buffer as 53 entries of nine bits each: a start-of-cell marker entry, then the 52 remaining cell bytes.

On the read side the consumer pulls an active-low read strobe that is asynchronous to the block clock. Each falling edge of the strobe delivers the next entry on `out_soc`/`out_data`. The consumer also watches the active-low `empty_n` flag. That flag drops while the last buffered entry is being delivered, and reads made after that point change nothing. A cell whose header check fails, or that arrives when the buffer lacks room for a whole cell, is discarded completely, and the matching counter is incremented.

Top module: `cra_rx_adapter`

## Requirements
- R1: A link cell is 53 consecutive `link_valid` bytes. `link_sop` is high on byte 0. Bytes 0..3 are the header, byte 4 is the header check and bytes 5..52 are the payload.
- R2: The expected header check is the CRC-8 of header bytes 0..3 (polynomial x^8+x^2+x+1, initial value 0x00, most significant bit first) XORed with 0x55. The check byte is never stored.
- R3: An accepted cell is read back as 53 entries. The first entry has `out_soc`=1 and an undefined data field. It is followed by the four header bytes and then the 48 payload bytes, in link order, each with `out_soc`=0.
- R4: A cell whose byte 4 differs from the expected header check is dropped whole. `hec_err_cnt` increases by one and no entry of the cell becomes readable.
- R5: A cell is accepted only if, when its byte 0 arrives, at least 53 buffer entries are free. Otherwise it is dropped whole and `ovf_cnt` increases by one.
- R6: `rd_n` passes through a two-flop synchroniser. Each high-to-low transition of `rd_n` consumes exactly one entry. That entry appears on `out_soc`/`out_data` at the third rising clock edge after `rd_n` goes low.
- R7: `empty_n` is 0 when no entry is buffered. It goes to 0 at the same clock edge that delivers the last buffered entry, and it goes to 1 within two clock edges after a cell is committed.
- R8: A read strobe while the buffer is empty has no effect. `out_soc` and `out_data` keep their values, and the next entry read after a later cell is committed is that cell's marker entry.
- R9: While `rst` is high, the buffer empties, `empty_n`, `out_soc`, `out_data`, `hec_err_cnt` and `ovf_cnt` go to 0, and any partly received cell is abandoned.
- R10: Two or more accepted cells are read back in arrival order, with no entries lost between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| link_valid | input | 1 | Link byte present this cycle |
| link_sop | input | 1 | Current link byte is byte 0 of a cell |
| link_byte | input | 8 | Link byte |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| out_soc | output | 1 | Start-of-cell marker bit of the last entry read |
| out_data | output | 8 | Data field of the last entry read |
| empty_n | output | 1 | Active-low empty flag |
| hec_err_cnt | output | CNT_W | Cells dropped for a header check mismatch (wraps) |
| ovf_cnt | output | CNT_W | Cells dropped for lack of room (wraps) |

## Verification
The bench keeps the default buffer depth of 128 entries and an 8-bit counter width. Two whole cells (106 entries) then fit, and a third cell sent back-to-back meets only 22 free entries. This makes the overflow drop reachable with three cells, and it gives a read-back sequence that crosses a cell boundary. The same depth makes the pointers wrap over repeated rounds of vectors, and the reads made before the last entry and on it expose the exact edge at which the empty flag falls.

// File: rtl/cra_pkg.sv
package cra_pkg;
  localparam int LINK_BYTES   = 53;
  localparam int HDR_BYTES    = 4;
  localparam int CELL_ENTRIES = 53;
  localparam int LAST_POS     = LINK_BYTES - 1;
  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;

  typedef struct packed {
    logic       soc;
    logic [7:0] data;
  } entry_t;

  // One byte through the header CRC, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/cra_hec_check.sv
module cra_hec_check
  import cra_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic       byte_sop,
  input  logic [5:0] pos,
  input  logic [7:0] byte_in,
  output logic       mismatch
);
  logic [7:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else if (byte_valid && byte_sop) begin
      crc_q <= crc8_step(8'h00, byte_in);
    end else if (byte_valid && pos < 6'(HDR_BYTES)) begin
      crc_q <= crc8_step(crc_q, byte_in);
    end
  end

  // Only meaningful when the current byte sits at the check position
  assign mismatch = (byte_in != (crc_q ^ HEC_COSET));
endmodule

// File: rtl/cra_cell_writer.sv
module cra_cell_writer
  import cra_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [7:0]    in_byte,
  input  logic [PW-1:0] rd_ptr,
  input  logic          hec_mismatch,
  output logic [5:0]    pos,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output entry_t        wr_entry,
  output logic [PW-1:0] wr_ptr,
  output logic [CNT_W-1:0] hec_err_cnt,
  output logic [CNT_W-1:0] ovf_cnt
);
  localparam logic [PW-1:0] ALL_FREE = PW'(DEPTH);
  localparam logic [PW-1:0] NEED     = PW'(CELL_ENTRIES);

  logic          active_q, keep_q, bad_q;
  logic [5:0]    pos_q;
  logic [PW-1:0] tmp_q, wr_ptr_q;
  logic [7:0]    hold_q;
  logic [CNT_W-1:0] hec_q, ovf_q;

  logic          start, step, room;
  logic [PW-1:0] used;

  assign start = in_valid && in_sop;
  assign step  = in_valid && !in_sop && active_q;
  assign used  = wr_ptr_q - rd_ptr;
  assign room  = (ALL_FREE - used) >= NEED;

  // Header bytes are written one slot late, which frees byte 0's slot for the marker
  always_comb begin
    wr_en    = start ? room : (step && keep_q);
    wr_addr  = start ? wr_ptr_q[AW-1:0] : tmp_q[AW-1:0];
    wr_entry = '{soc: 1'b0, data: in_byte};
    if (start)
      wr_entry = '{soc: 1'b1, data: 8'h00};
    else if (pos_q <= 6'(HDR_BYTES))
      wr_entry = '{soc: 1'b0, data: hold_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      keep_q   <= 1'b0;
      bad_q    <= 1'b0;
      pos_q    <= '0;
      tmp_q    <= '0;
      wr_ptr_q <= '0;
      hold_q   <= '0;
      hec_q    <= '0;
      ovf_q    <= '0;
    end else begin
      if (in_valid) hold_q <= in_byte;
      if (start) begin
        active_q <= 1'b1;
        pos_q    <= 6'd1;
        keep_q   <= room;
        bad_q    <= 1'b0;
        tmp_q    <= wr_ptr_q + PW'(1);
        if (!room) ovf_q <= ovf_q + CNT_W'(1);
      end else if (step) begin
        tmp_q <= tmp_q + PW'(1);
        pos_q <= pos_q + 6'd1;
        if (pos_q == 6'(HDR_BYTES)) bad_q <= hec_mismatch;
        if (pos_q == 6'(LAST_POS)) begin
          active_q <= 1'b0;
          if (keep_q) begin
            if (bad_q) hec_q <= hec_q + CNT_W'(1);
            else       wr_ptr_q <= tmp_q + PW'(1);
          end
        end
      end
    end
  end

  assign pos         = pos_q;
  assign wr_ptr      = wr_ptr_q;
  assign hec_err_cnt = hec_q;
  assign ovf_cnt     = ovf_q;
endmodule

// File: rtl/cra_entry_ram.sv
module cra_entry_ram
  import cra_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  entry_t        wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output entry_t        rdata
);
  entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cra_read_port.sv
module cra_read_port #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_n_async,
  input  logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_fall,
  output logic          empty_n
);
  logic s1_q, s2_q, s3_q, empty_n_q;
  logic [PW-1:0] rd_ptr_q, rd_ptr_nxt;

  assign rd_fall    = s3_q && !s2_q;
  assign rd_en      = rd_fall && (wr_ptr != rd_ptr_q);
  assign rd_ptr_nxt = rd_ptr_q + PW'(rd_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q      <= 1'b1;
      s2_q      <= 1'b1;
      s3_q      <= 1'b1;
      rd_ptr_q  <= '0;
      empty_n_q <= 1'b0;
    end else begin
      s1_q      <= rd_n_async;
      s2_q      <= s1_q;
      s3_q      <= s2_q;
      rd_ptr_q  <= rd_ptr_nxt;
      empty_n_q <= (wr_ptr != rd_ptr_nxt);
    end
  end

  assign rd_ptr  = rd_ptr_q;
  assign rd_addr = rd_ptr_q[AW-1:0];
  assign empty_n = empty_n_q;
endmodule

// File: rtl/cra_rx_adapter.sv
module cra_rx_adapter
  import cra_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_valid,
  input  logic             link_sop,
  input  logic [7:0]       link_byte,
  input  logic             rd_n,
  output logic             out_soc,
  output logic [7:0]       out_data,
  output logic             empty_n,
  output logic [CNT_W-1:0] hec_err_cnt,
  output logic [CNT_W-1:0] ovf_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [5:0]    pos;
  logic          hec_mismatch, wr_en, rd_en, rd_fall;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_ptr, rd_ptr;
  entry_t        wr_entry, rd_entry;

  cra_hec_check u_hec (
    .clk(clk), .rst(rst), .byte_valid(link_valid), .byte_sop(link_sop),
    .pos(pos), .byte_in(link_byte), .mismatch(hec_mismatch)
  );

  cra_cell_writer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .in_valid(link_valid), .in_sop(link_sop),
    .in_byte(link_byte), .rd_ptr(rd_ptr), .hec_mismatch(hec_mismatch),
    .pos(pos), .wr_en(wr_en), .wr_addr(wr_addr), .wr_entry(wr_entry),
    .wr_ptr(wr_ptr), .hec_err_cnt(hec_err_cnt), .ovf_cnt(ovf_cnt)
  );

  cra_entry_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_entry),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_entry)
  );

  cra_read_port #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .rd_n_async(rd_n), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_fall(rd_fall), .empty_n(empty_n)
  );

  assign out_soc  = rd_entry.soc;
  assign out_data = rd_entry.data;
endmodule

// File: rtl/cra_rx_adapter_chk.sv
module cra_rx_adapter_chk #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [PW-1:0]    wr_ptr,
  input logic [PW-1:0]    rd_ptr,
  input logic             rd_fall,
  input logic             empty_n,
  input logic             out_soc,
  input logic [7:0]       out_data,
  input logic [CNT_W-1:0] hec_err_cnt,
  input logic [CNT_W-1:0] ovf_cnt
);
  initial begin
    assert (DEPTH >= 106 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two holding two cells");
  end

  p_span_r5: assert property (@(posedge clk) disable iff (rst)
    (PW'(wr_ptr - rd_ptr) <= PW'(DEPTH)));

  p_whole_cell_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wr_ptr == $past(wr_ptr) || wr_ptr == PW'($past(wr_ptr) + PW'(53))));

  p_empty_truth_r7: assert property (@(posedge clk) disable iff (rst)
    empty_n |-> (wr_ptr != rd_ptr));

  p_empty_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != rd_ptr && !rd_fall) |=> empty_n);

  p_idle_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_fall && wr_ptr == rd_ptr) |=> ($stable(out_soc) && $stable(out_data) && $stable(rd_ptr)));

  p_hec_step_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hec_err_cnt == $past(hec_err_cnt) || hec_err_cnt == CNT_W'($past(hec_err_cnt) + CNT_W'(1))));

  p_ovf_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ovf_cnt == $past(ovf_cnt) || ovf_cnt == CNT_W'($past(ovf_cnt) + CNT_W'(1))));
endmodule

bind cra_rx_adapter cra_rx_adapter_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_fall(rd_fall),
  .empty_n(empty_n), .out_soc(out_soc), .out_data(out_data),
  .hec_err_cnt(hec_err_cnt), .ovf_cnt(ovf_cnt)
);

// File: tb/cra_rx_adapter_bench.sv
module cra_rx_adapter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_valid = 1'b0, link_sop = 1'b0;
  logic [7:0] link_byte = 8'h00;
  logic rd_n = 1'b1;
  logic out_soc, empty_n;
  logic [7:0] out_data, hec_err_cnt, ovf_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cra_rx_adapter u_cra_rx_adapter (
    .clk(clk), .rst(rst), .link_valid(link_valid), .link_sop(link_sop),
    .link_byte(link_byte), .rd_n(rd_n), .out_soc(out_soc), .out_data(out_data),
    .empty_n(empty_n), .hec_err_cnt(hec_err_cnt), .ovf_cnt(ovf_cnt)
  );

  // {corrupt check byte, seed}
  localparam logic [8:0] VEC [5] = '{9'h010, 9'h122, 9'h0A5, 9'h03C, 9'h1F0};

  function automatic logic [7:0] cb(input logic [7:0] seed, input int j);
    return seed + 8'(j * 13) ^ 8'(j);
  endfunction

  function automatic logic [7:0] ref_hec(input logic [7:0] seed);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < 4; b++) begin
      c = c ^ cb(seed, b);
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cell(input logic [7:0] seed, input bit corrupt);
    for (int k = 0; k < 53; k++) begin
      @(negedge clk);
      link_valid = 1'b1;
      link_sop   = (k == 0);
      if (k < 4)       link_byte = cb(seed, k);
      else if (k == 4) link_byte = ref_hec(seed) ^ (corrupt ? 8'h01 : 8'h00);
      else             link_byte = cb(seed, k - 1);
    end
    @(negedge clk);
    link_valid = 1'b0;
    link_sop   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R6: output settles at the third rising edge after rd_n falls
  task automatic read_entry();
    @(negedge clk);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_rd();
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R3/R7/R10: read back a whole cell and compare
  task automatic read_cell(input logic [7:0] seed);
    read_entry();
    check(out_soc == 1'b1, "R3 marker", out_soc, 1);
    release_rd();
    for (int j = 0; j < 52; j++) begin
      read_entry();
      check(out_soc == 1'b0 && out_data == cb(seed, j), "R3 R2 cell byte",
            {out_soc, out_data}, {1'b0, cb(seed, j)});
      if (j == 50) check(empty_n == 1'b1, "R7 before last", empty_n, 1);
      release_rd();
    end
  endtask

  initial begin
    logic [7:0] h0, o0;
    logic s0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(empty_n == 0 && out_soc == 0 && out_data == 0, "R9 reset outputs",
          {empty_n, out_soc, out_data}, 0);
    check(hec_err_cnt == 0 && ovf_cnt == 0, "R9 reset counters", {hec_err_cnt, ovf_cnt}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R4 R7: vector table
    for (int v = 0; v < 5; v++) begin
      h0 = hec_err_cnt;
      send_cell(VEC[v][7:0], VEC[v][8]);
      if (VEC[v][8]) begin
        check(hec_err_cnt == h0 + 8'd1, "R4 bad check counted", hec_err_cnt, h0 + 8'd1);
        check(empty_n == 1'b0, "R4 bad cell not stored", empty_n, 0);
      end else begin
        check(empty_n == 1'b1, "R7 commit raises flag", empty_n, 1);
        read_cell(VEC[v][7:0]);
        check(empty_n == 1'b0, "R7 flag low with last entry", empty_n, 0);
      end
    end

    // R8: read while empty leaves outputs alone
    s0 = out_soc; o0 = out_data;
    read_entry();
    check(out_soc == s0 && out_data == o0, "R8 idle read outputs", {out_soc, out_data}, {s0, o0});
    release_rd();
    send_cell(8'h5A, 1'b0);
    read_entry();
    check(out_soc == 1'b1, "R8 next read is marker", out_soc, 1);
    release_rd();
    for (int j = 0; j < 52; j++) begin
      read_entry();
      release_rd();
    end

    // R5 R10: third back-to-back cell overflows
    send_cell(8'h11, 1'b0);
    send_cell(8'h77, 1'b0);
    send_cell(8'h99, 1'b0);
    check(ovf_cnt == 8'd1, "R5 overflow counted", ovf_cnt, 1);
    read_cell(8'h11);
    check(empty_n == 1'b1, "R10 second cell waiting", empty_n, 1);
    read_cell(8'h77);
    check(empty_n == 1'b0, "R5 third cell dropped", empty_n, 0);

    // R9: reset abandons a partial cell and clears counters
    send_cell(8'h33, 1'b1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      link_valid = 1'b1;
      link_sop   = (k == 0);
      link_byte  = 8'(k);
    end
    rst = 1'b1;
    link_valid = 1'b0;
    link_sop = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(hec_err_cnt == 0 && ovf_cnt == 0 && empty_n == 0, "R9 mid-cell reset",
          {hec_err_cnt, ovf_cnt, empty_n}, 0);
    rst = 1'b0;
    send_cell(8'hC3, 1'b0);
    read_cell(8'hC3);
    check(empty_n == 1'b0, "R9 clean restart", empty_n, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule